// File: doc/BRIEF.md
# Indirect PHY Register Window

This block lets a host reach a small 8-bit PHY register space through two words of its own register map. The command word holds three things: the PHY offset in its low byte, a direction bit, and a read-only busy flag. The data word is an 8-bit window for the value.

To write a PHY register, the host first loads the data word. It then writes the command word with the direction bit set. To read, it writes the command word with the direction bit clear. It polls busy, and when busy drops it reads the result from the data word.

On the PHY side the block drives a simple request/ready register bus. A watchdog gives up on a PHY that never answers. It then reports the failure through a sticky error flag.

Top module: `phy_reg_window`

## Requirements
- R1: After reset, busy, the error flag and the data word are all zero and `phy_req` is low.
- R2: The command word sits at host offset 0x300 and the data word at 0x304. In the command word, bits 7:0 hold the PHY offset, bit 8 is 1 for write and 0 for read, bit 9 is busy and bit 10 is the error flag. When idle, a host write of the command word raises `phy_req` from the next cycle, with `phy_addr` equal to bits 7:0 and `phy_we` equal to bit 8.
- R3: On a PHY write access, `phy_wdata` carries the value held in the data word.
- R4: Busy and `phy_req` stay high from the cycle after the command write until the cycle after `phy_ready` is seen with `phy_req`. With a ready latency of k idle cycles, the request lasts k+1 cycles.
- R5: On a PHY read access, the `phy_rdata` presented with `phy_ready` is loaded into the low 8 bits of the data word.
- R6: Bits 31:8 of the data word always read as zero. A host write stores only bits 7:0.
- R7: A host write of the command word while busy is ignored. No second access is started, and offset and direction are unchanged.
- R8: A host write of the data word while busy is ignored.
- R9: If no ready arrives within `wd_limit` cycles of the request (a limit of 0 acts as 1), the access is aborted. Busy clears and the error flag is set. A ready arriving in the last allowed cycle completes the access normally.
- R10: The error flag stays set until reset, and later accesses still work.
- R11: `phy_ready` asserted while no access is in progress has no effect.
- R12: Host offsets other than the two words read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | HOST_DW | Host write data |
| host_rdata | output | HOST_DW | Host read data for `host_addr` (combinational) |
| wd_limit | input | WD_W | Watchdog limit in cycles |
| phy_req | output | 1 | PHY access in progress |
| phy_we | output | 1 | PHY access is a write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write data |
| phy_rdata | input | 8 | PHY read data, valid with `phy_ready` |
| phy_ready | input | 1 | PHY completes the access |

## Verification
A full sweep writes a distinct arithmetic value to every one of the 256 PHY offsets and then reads each one back. The ready latency rotates through 0 to 3 cycles, so offset decoding, write-data routing, read capture and request length are each separated per offset. Directed sequences cover further cases:
- A command and a data write issued mid-access, which must leave the access count and the stored values untouched.
- A silent PHY under several watchdog limits, and a ready in exactly the last allowed cycle, which separates an abort from a completion.
- A stray ready while idle, and writes to an unmapped offset.

// File: rtl/phy_reg_window.sv
module phy_reg_window #(
  parameter int ADDR_W = 12,
  parameter int HOST_DW = 32,
  parameter int WD_W = 8,
  parameter logic [ADDR_W-1:0] CMD_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h304
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic [WD_W-1:0]    wd_limit,
  output logic               phy_req,
  output logic               phy_we,
  output logic [7:0]         phy_addr,
  output logic [7:0]         phy_wdata,
  input  logic [7:0]         phy_rdata,
  input  logic               phy_ready
);
  localparam int DIR_BIT = 8;
  localparam int CNT_W = WD_W + 1;

  logic busy_q, err_q, we_q;
  logic [7:0] off_q, data_q;
  logic [WD_W-1:0] wd_cnt;

  wire cmd_hit = host_we && (host_addr == CMD_OFF);
  wire dat_hit = host_we && (host_addr == DATA_OFF);
  wire start   = cmd_hit && !busy_q;
  wire done    = busy_q && phy_ready;
  wire expire  = busy_q && !phy_ready &&
                 ((CNT_W'(wd_cnt) + CNT_W'(1)) >= CNT_W'(wd_limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b0;
      off_q  <= '0;
      data_q <= '0;
      wd_cnt <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        off_q  <= host_wdata[7:0];
        we_q   <= host_wdata[DIR_BIT];
        wd_cnt <= '0;
      end else if (done) begin
        busy_q <= 1'b0;
        if (!we_q) data_q <= phy_rdata;
      end else if (expire) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else if (busy_q) begin
        wd_cnt <= wd_cnt + 1'b1;
      end
      if (dat_hit && !busy_q) data_q <= host_wdata[7:0];
    end
  end

  assign phy_req   = busy_q;
  assign phy_we    = we_q;
  assign phy_addr  = off_q;
  assign phy_wdata = data_q;

  always_comb begin
    host_rdata = '0;
    if (host_addr == CMD_OFF)
      host_rdata = HOST_DW'({err_q, busy_q, we_q, off_q});
    else if (host_addr == DATA_OFF)
      host_rdata = HOST_DW'(data_q);
  end
endmodule

module phy_reg_window_chk #(
  parameter int ADDR_W = 12,
  parameter int HOST_DW = 32,
  parameter logic [ADDR_W-1:0] CMD_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h304
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [HOST_DW-1:0] host_wdata,
  input logic [HOST_DW-1:0] host_rdata,
  input logic               phy_req,
  input logic               phy_we,
  input logic [7:0]         phy_addr,
  input logic [7:0]         phy_wdata,
  input logic [7:0]         phy_rdata,
  input logic               phy_ready,
  input logic               err_q
);
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == CMD_OFF && !phy_req) |=>
      (phy_req && phy_addr == $past(host_wdata[7:0]) && phy_we == $past(host_wdata[8]))); // R2
  AST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ready) |=> !phy_req); // R4
  AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ready && !phy_we) |=> (phy_wdata == $past(phy_rdata))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == DATA_OFF) |-> (host_rdata[HOST_DW-1:8] == '0)); // R6
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ready && host_we) |=>
      ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R10
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_req && phy_ready && !host_we) |=> (!phy_req && $stable(phy_wdata))); // R11
endmodule

bind phy_reg_window phy_reg_window_chk #(
  .ADDR_W(ADDR_W), .HOST_DW(HOST_DW), .CMD_OFF(CMD_OFF), .DATA_OFF(DATA_OFF)
) i_phy_reg_window_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req(phy_req),
  .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
  .phy_rdata(phy_rdata), .phy_ready(phy_ready), .err_q(err_q)
);

// File: tb/test_phy_reg_window.sv
module test_phy_reg_window;
  localparam logic [11:0] CMD = 12'h300;
  localparam logic [11:0] DAT = 12'h304;

  logic clk = 0, rst_n = 0, host_we = 0;
  logic [11:0] host_addr = CMD;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [7:0] wd_limit = 8'd200;
  logic phy_req, phy_we, phy_ready = 0;
  logic [7:0] phy_addr, phy_wdata, phy_rdata = 0;

  int checks = 0, errors = 0, n_acc = 0, wcnt = 0, lat_cfg = 0;
  bit mute = 0, stray = 0, finished = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  phy_reg_window i_phy_reg_window (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wd_limit(wd_limit),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ready(phy_ready)
  );

  always @(negedge clk) begin
    if (phy_req && !mute) begin
      if (wcnt == lat_cfg) begin
        phy_ready = 1;
        phy_rdata = phy_we ? 8'h00 : mem[phy_addr];
        if (phy_we) mem[phy_addr] = phy_wdata;
        n_acc++;
        wcnt = 0;
      end else begin
        phy_ready = 0;
        wcnt++;
      end
    end else begin
      phy_ready = stray;
      wcnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0; host_addr = CMD;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (phy_req && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] off, input int lat, output int n);
    lat_cfg = lat;
    host_write(CMD, {23'd0, wr, off});
    wait_idle(n);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    host_addr = a; #1; v = host_rdata; host_addr = CMD;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, a0;
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    do_reset();
    rd(CMD, v); chk("R1 cmd word", v, 32'h0);
    rd(DAT, v); chk("R1 data word", v, 32'h0);
    chk("R1 phy_req", {31'd0, phy_req}, 32'd0);

    for (int o = 0; o < 256; o++) begin
      host_write(DAT, 32'((o * 37 + 11) & 8'hFF));
      access(1'b1, 8'(o), o % 4, n);
      chk("R3 write data", {24'd0, mem[o]}, 32'((o * 37 + 11) & 8'hFF));
      chk("R4 write length", 32'(n), 32'(o % 4 + 1));
    end
    for (int o = 0; o < 256; o++) begin
      access(1'b0, 8'(o), (o + 1) % 4, n);
      chk("R4 read length", 32'(n), 32'((o + 1) % 4 + 1));
      rd(DAT, v); chk("R5 R6 read data", v, 32'((o * 37 + 11) & 8'hFF));
      rd(CMD, v); chk("R2 cmd readback", v, 32'(o));
    end

    host_write(DAT, 32'hFFFF_FF3C);
    rd(DAT, v); chk("R6 upper bits", v, 32'h3C);

    lat_cfg = 2;
    host_write(CMD, 32'h1A5);
    rd(CMD, v); chk("R2 busy set", v, 32'h3A5);
    chk("R2 phy_addr", {24'd0, phy_addr}, 32'hA5);
    chk("R2 phy_we", {31'd0, phy_we}, 32'd1);
    wait_idle(n);

    mem[8'h10] = 8'h00; mem[8'h20] = 8'h77;
    host_write(DAT, 32'h5A);
    a0 = n_acc;
    lat_cfg = 3;
    host_write(CMD, 32'h110);
    host_write(CMD, 32'h020);
    host_write(DAT, 32'hC3);
    wait_idle(n);
    chk("R7 single access", 32'(n_acc - a0), 32'd1);
    chk("R7 write landed", {24'd0, mem[8'h10]}, 32'h5A);
    chk("R7 second target untouched", {24'd0, mem[8'h20]}, 32'h77);
    rd(CMD, v); chk("R7 cmd unchanged", v, 32'h110);
    rd(DAT, v); chk("R8 data unchanged", v, 32'h5A);

    wd_limit = 4;
    access(1'b0, 8'h20, 3, n);
    rd(CMD, v); chk("R9 ready in last cycle", v, 32'h020);
    rd(DAT, v); chk("R9 ready in last cycle data", v, 32'h77);

    a0 = n_acc;
    stray = 1;
    repeat (4) @(negedge clk);
    stray = 0;
    @(negedge clk);
    chk("R11 no access", 32'(n_acc - a0), 32'd0);
    rd(CMD, v); chk("R11 not busy", v, 32'h020);
    rd(DAT, v); chk("R11 data kept", v, 32'h77);

    host_write(12'h308, 32'hFFFF_FFFF);
    rd(12'h308, v); chk("R12 unmapped read", v, 32'h0);
    rd(DAT, v); chk("R12 data kept", v, 32'h77);
    rd(CMD, v); chk("R12 cmd kept", v, 32'h020);

    mute = 1; wd_limit = 5;
    access(1'b0, 8'h33, 0, n);
    chk("R9 abort length 5", 32'(n), 32'd5);
    rd(CMD, v); chk("R9 error set busy clear", v, 32'h433);
    wd_limit = 0;
    access(1'b0, 8'h34, 0, n);
    chk("R9 limit 0 length", 32'(n), 32'd1);
    wd_limit = 1;
    access(1'b0, 8'h35, 0, n);
    chk("R9 limit 1 length", 32'(n), 32'd1);
    mute = 0; wd_limit = 200;
    access(1'b0, 8'h20, 1, n);
    rd(DAT, v); chk("R10 access after error", v, 32'h77);
    rd(CMD, v); chk("R10 error sticky", v, 32'h420);

    do_reset();
    rd(CMD, v); chk("R1 cmd after reset", v, 32'h0);
    rd(DAT, v); chk("R1 data after reset", v, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule